// File: doc/BRIEF.md
# Flash Address Privilege Bitmap Bank

This block keeps two permission bitmaps for a serial flash device, one for read accesses and one for write accesses. Each bitmap has one bit per 16 KiB block of a 256 MiB flash address space. A bit value of 1 grants access to that block, and a bit value of 0 denies it. A transaction filter in front of the flash uses two combinational lookup ports. It presents a flash address on each port and gets back whether a read or a write to that address is allowed.

Software programs the bitmaps through a simple register port. A single window of 32-bit words gives access to the bitmaps. The top byte of a control register decides which bitmap the window reaches. Once the policy is in place, software sets a one-way lock bit. After that the bitmaps are frozen until a full reset, and any attempt to change them is recorded in a sticky error flag.

Top module: `addr_priv_bank`

## Requirements
- R1: After reset, every bit of both bitmaps is 0. The control register reads 0, the lock register reads 0 and the status register reads 0. Both lookup outputs are therefore 0 for every address.
- R2: When control bits [31:24] hold 0x52, a write to window word i (bus word address 0x200 + i) stores the data into word i of the read bitmap. A read of window word i then returns that word from the read bitmap.
- R3: When control bits [31:24] hold 0x57, window writes and window reads reach the write bitmap instead. The read bitmap is left unchanged.
- R4: When control bits [31:24] hold any value other than 0x52 or 0x57, window writes change neither bitmap and window reads return 0.
- R5: For a lookup address A below 0x1000_0000, the permit output equals bit (A mod 512 KiB) / 16 KiB of bitmap word A / 512 KiB. The read port uses the read bitmap and the write port uses the write bitmap. The result appears in the same cycle as the address, and a bitmap write is visible from the cycle after that write.
- R6: Any lookup address at or above 0x1000_0000 returns 0 on both permit outputs, whatever the bitmap contents.
- R7: The lock register is at bus word 0x001, bit 0. Writing 1 to it sets the lock. Writing 0 never clears it, and only reset clears it.
- R8: While the lock is set, every window write is dropped and both bitmaps keep their contents. The write sets status bit 0 (bus word 0x002), and that bit stays set until reset.
- R9: The control register is at bus word 0x000. It stores and reads back all 32 bits written to it, and it stays writable while the lock is set. Other non-window addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 10 | Register word address; bit 9 set selects the bitmap window |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| rd_chk_addr | input | 32 | Flash byte address to test for read permission |
| rd_chk_ok | output | 1 | Read permitted at rd_chk_addr |
| wr_chk_addr | input | 32 | Flash byte address to test for write permission |
| wr_chk_ok | output | 1 | Write permitted at wr_chk_addr |

## Verification
The lookup ports are driven each cycle with a mix of address patterns:
- Fully random addresses exercise the decode across the whole space, including the part above the flash space.
- Addresses clustered inside the programmed low words and inside the topmost word separate a correct word and bit split from a shifted or swapped one.
- The exact boundary addresses 0x0FFF_FFFF and 0x1000_0000 and addresses on 16 KiB block edges pin down the range cut-off and the block granularity.

Window traffic is run under each selector value: read table, write table and two invalid bytes. It is then repeated after locking, which tells apart misrouted writes, writes that leak through an invalid selector and writes that leak past the lock.

// File: rtl/abp_pkg.sv
package abp_pkg;

  localparam logic [7:0] SEL_CODE_RD = 8'h52;
  localparam logic [7:0] SEL_CODE_WR = 8'h57;

  typedef enum logic [1:0] {
    TSEL_NONE = 2'd0,
    TSEL_RD   = 2'd1,
    TSEL_WR   = 2'd2
  } tsel_e;

  // Turn the control top byte into a table choice.
  function automatic tsel_e decode_sel(input logic [7:0] code);
    if (code == SEL_CODE_RD) return TSEL_RD;
    if (code == SEL_CODE_WR) return TSEL_WR;
    return TSEL_NONE;
  endfunction

endpackage

// File: rtl/abp_regs.sv
module abp_regs
  import abp_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int BUS_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              win_hit,
  output logic              win_wr_req,
  output tsel_e             tsel,
  output logic [7:0]        ctrl_sel,
  output logic [1:0]        tbl_we,
  output logic              lock_q,
  output logic              err_q
);

  logic [REG_W-1:0] ctrl_q;
  logic ctrl_hit, lock_hit, stat_hit, win_wr_blocked;

  always_comb begin
    win_hit  = bus_addr[BUS_AW-1];
    ctrl_hit = !win_hit && (bus_addr[BUS_AW-2:0] == (BUS_AW-1)'(0));
    lock_hit = !win_hit && (bus_addr[BUS_AW-2:0] == (BUS_AW-1)'(1));
    stat_hit = !win_hit && (bus_addr[BUS_AW-2:0] == (BUS_AW-1)'(2));
    ctrl_sel = ctrl_q[REG_W-1 -: 8];
    tsel     = decode_sel(ctrl_sel);
    win_wr_req     = bus_we && win_hit;
    win_wr_blocked = win_wr_req && lock_q;
    tbl_we[0] = win_wr_req && !lock_q && (tsel == TSEL_RD);
    tbl_we[1] = win_wr_req && !lock_q && (tsel == TSEL_WR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (bus_we && ctrl_hit) ctrl_q <= bus_wdata;
      if (bus_we && lock_hit && bus_wdata[0]) lock_q <= 1'b1;
      if (win_wr_blocked) err_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (ctrl_hit)      reg_rdata = ctrl_q;
    else if (lock_hit) reg_rdata[0] = lock_q;
    else if (stat_hit) reg_rdata[0] = err_q;
  end

endmodule

// File: rtl/abp_table.sv
module abp_table #(
  parameter int REG_W = 32,
  parameter int IDX_W = 9,
  localparam int BIT_W     = $clog2(REG_W),
  localparam int NUM_WORDS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [REG_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [REG_W-1:0] rdata,
  input  logic [IDX_W-1:0] chk_word,
  input  logic [BIT_W-1:0] chk_bit,
  input  logic             chk_valid,
  output logic             chk_ok
);

  logic [REG_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[widx] <= wdata;
    end
  end

  logic [REG_W-1:0] chk_word_val;

  always_comb begin
    rdata        = mem_q[ridx];
    chk_word_val = mem_q[chk_word];
    chk_ok       = chk_valid && chk_word_val[chk_bit];
  end

endmodule

// File: rtl/addr_priv_bank.sv
module addr_priv_bank
  import abp_pkg::*;
#(
  parameter int FLASH_AW    = 28,
  parameter int BLOCK_SHIFT = 14,
  parameter int REG_W       = 32,
  parameter int CHK_AW      = 32,
  localparam int BIT_W      = $clog2(REG_W),
  localparam int WORD_SHIFT = BLOCK_SHIFT + BIT_W,
  localparam int IDX_W      = FLASH_AW - WORD_SHIFT,
  localparam int BUS_AW     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [CHK_AW-1:0] rd_chk_addr,
  output logic              rd_chk_ok,
  input  logic [CHK_AW-1:0] wr_chk_addr,
  output logic              wr_chk_ok
);

  // Address split helpers: block bit within a word, word within a table.
  function automatic logic in_space(input logic [CHK_AW-1:0] a);
    return (a >> FLASH_AW) == '0;
  endfunction

  function automatic logic [IDX_W-1:0] word_of(input logic [CHK_AW-1:0] a);
    return a[WORD_SHIFT +: IDX_W];
  endfunction

  function automatic logic [BIT_W-1:0] bit_of(input logic [CHK_AW-1:0] a);
    return a[BLOCK_SHIFT +: BIT_W];
  endfunction

  logic [REG_W-1:0] reg_rdata;
  logic             win_hit, win_wr_req, lock_q, err_q;
  tsel_e            tsel;
  logic [7:0]       ctrl_sel;
  logic [1:0]       tbl_we;
  logic [IDX_W-1:0] win_idx;
  logic [REG_W-1:0] tbl_rdata [2];
  logic [IDX_W-1:0] chk_word  [2];
  logic [BIT_W-1:0] chk_bit   [2];
  logic [1:0]       chk_valid;
  logic [1:0]       chk_ok;

  assign win_idx = bus_addr[IDX_W-1:0];

  abp_regs #(.REG_W(REG_W), .BUS_AW(BUS_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .reg_rdata (reg_rdata),
    .win_hit   (win_hit),
    .win_wr_req(win_wr_req),
    .tsel      (tsel),
    .ctrl_sel  (ctrl_sel),
    .tbl_we    (tbl_we),
    .lock_q    (lock_q),
    .err_q     (err_q)
  );

  always_comb begin
    chk_word[0]  = word_of(rd_chk_addr);
    chk_bit[0]   = bit_of(rd_chk_addr);
    chk_valid[0] = in_space(rd_chk_addr);
    chk_word[1]  = word_of(wr_chk_addr);
    chk_bit[1]   = bit_of(wr_chk_addr);
    chk_valid[1] = in_space(wr_chk_addr);
  end

  // Table 0 grants reads, table 1 grants writes.
  for (genvar t = 0; t < 2; t++) begin : g_tbl
    abp_table #(.REG_W(REG_W), .IDX_W(IDX_W)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (tbl_we[t]),
      .widx     (win_idx),
      .wdata    (bus_wdata),
      .ridx     (win_idx),
      .rdata    (tbl_rdata[t]),
      .chk_word (chk_word[t]),
      .chk_bit  (chk_bit[t]),
      .chk_valid(chk_valid[t]),
      .chk_ok   (chk_ok[t])
    );
  end

  assign rd_chk_ok = chk_ok[0];
  assign wr_chk_ok = chk_ok[1];

  always_comb begin
    if (!win_hit)              bus_rdata = reg_rdata;
    else if (tsel == TSEL_RD)  bus_rdata = tbl_rdata[0];
    else if (tsel == TSEL_WR)  bus_rdata = tbl_rdata[1];
    else                       bus_rdata = '0;
  end

endmodule

// File: rtl/abp_checker.sv
module abp_checker #(
  parameter int FLASH_AW = 28,
  parameter int CHK_AW   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_q,
  input logic              err_q,
  input logic              win_wr_req,
  input logic [1:0]        tbl_we,
  input logic [7:0]        ctrl_sel,
  input logic [CHK_AW-1:0] rd_chk_addr,
  input logic              rd_chk_ok,
  input logic [CHK_AW-1:0] wr_chk_addr,
  input logic              wr_chk_ok
);

  assert_one_table_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tbl_we));

  assert_bad_sel_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_sel != 8'h52 && ctrl_sel != 8'h57) |-> (tbl_we == 2'b00));

  assert_rd_out_of_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_chk_addr >> FLASH_AW) != '0) |-> !rd_chk_ok);

  assert_wr_out_of_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_chk_addr >> FLASH_AW) != '0) |-> !wr_chk_ok);

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_locked_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (tbl_we == 2'b00));

  assert_err_on_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr_req && lock_q) |=> err_q);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

bind addr_priv_bank abp_checker #(.FLASH_AW(FLASH_AW), .CHK_AW(CHK_AW)) u_abp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .lock_q     (lock_q),
  .err_q      (err_q),
  .win_wr_req (win_wr_req),
  .tbl_we     (tbl_we),
  .ctrl_sel   (ctrl_sel),
  .rd_chk_addr(rd_chk_addr),
  .rd_chk_ok  (rd_chk_ok),
  .wr_chk_addr(wr_chk_addr),
  .wr_chk_ok  (wr_chk_ok)
);

// File: tb/test_addr_priv_bank.sv
module test_addr_priv_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] rd_chk_addr = '0;
  logic        rd_chk_ok;
  logic [31:0] wr_chk_addr = '0;
  logic        wr_chk_ok;

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  string       cur_req = "R1";
  int          addr_mode = 0;

  always #10 clk = ~clk;

  addr_priv_bank i_addr_priv_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_chk_addr(rd_chk_addr), .rd_chk_ok(rd_chk_ok),
    .wr_chk_addr(wr_chk_addr), .wr_chk_ok(wr_chk_ok)
  );

  // Behavioural reference model.
  logic [31:0] m_rd [512];
  logic [31:0] m_wr [512];
  logic [31:0] m_ctrl = '0;
  logic        m_lock = 1'b0;
  logic        m_err  = 1'b0;

  initial for (int i = 0; i < 512; i++) begin m_rd[i] = '0; m_wr[i] = '0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) begin m_rd[i] = '0; m_wr[i] = '0; end
      m_ctrl = '0; m_lock = 1'b0; m_err = 1'b0;
    end else if (bus_we) begin
      int unsigned a;
      a = bus_addr;
      if (a >= 512) begin
        if (m_lock) m_err = 1'b1;
        else if (m_ctrl[31:24] == 8'h52) m_rd[a-512] = bus_wdata;
        else if (m_ctrl[31:24] == 8'h57) m_wr[a-512] = bus_wdata;
      end else if (a == 0) m_ctrl = bus_wdata;
      else if (a == 1 && bus_wdata[0]) m_lock = 1'b1;
    end
  end

  function automatic logic model_permit(input logic [31:0] addr, input bit use_wr);
    int unsigned a, w, b;
    logic [31:0] word;
    a = addr;
    if (a >= 32'h1000_0000) return 1'b0;
    w = a / 524288;
    b = (a % 524288) / 16384;
    word = use_wr ? m_wr[w] : m_rd[w];
    return word[b];
  endfunction

  function automatic logic [31:0] model_rdata(input logic [9:0] ba);
    int unsigned a;
    a = ba;
    if (a >= 512) begin
      if (m_ctrl[31:24] == 8'h52) return m_rd[a-512];
      if (m_ctrl[31:24] == 8'h57) return m_wr[a-512];
      return 32'h0;
    end
    if (a == 0) return m_ctrl;
    if (a == 1) return {31'h0, m_lock};
    if (a == 2) return {31'h0, m_err};
    return 32'h0;
  endfunction

  task automatic cmp(input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cmp("bus_rdata", bus_rdata, model_rdata(bus_addr));
    cmp("rd_chk_ok", {31'h0, rd_chk_ok}, {31'h0, model_permit(rd_chk_addr, 1'b0)});
    cmp("wr_chk_ok", {31'h0, wr_chk_ok}, {31'h0, model_permit(wr_chk_addr, 1'b1)});
  end

  function automatic logic [31:0] pick_addr();
    int unsigned r;
    r = $urandom;
    if (addr_mode == 1) return 32'h1000_0000 + ($urandom % 32'hF000_0000);
    case (r % 5)
      0: return $urandom;
      1: return (($urandom % 8) * 524288) + ($urandom % 524288);
      2: return 32'h0FF8_0000 + ($urandom % 524288);
      3: return ($urandom % 2 == 0) ? 32'h0FFF_FFFF : 32'h1000_0000;
      default: return (($urandom % 8) * 524288) + (($urandom % 32) * 16384)
                      + (($urandom % 2 == 0) ? 32'h0 : 32'h3FFF);
    endcase
  endfunction

  task automatic drive(input logic we, input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = we; bus_addr = a; bus_wdata = d;
    rd_chk_addr = pick_addr();
    wr_chk_addr = pick_addr();
  endtask

  task automatic fill_words();
    for (int i = 0; i < 8; i++) drive(1'b1, 10'(512 + i), $urandom);
    drive(1'b1, 10'd1023, $urandom);
  endtask

  task automatic read_words();
    for (int i = 0; i < 8; i++) drive(1'b0, 10'(512 + i), 32'h0);
    drive(1'b0, 10'd1023, 32'h0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) drive(1'b0, 10'd0, 32'h0);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 4; i++) drive(1'b0, 10'(i), 32'h0);
    read_words();

    cur_req = "R2";
    drive(1'b1, 10'd0, 32'h5200_0000);
    fill_words();
    read_words();

    cur_req = "R3";
    drive(1'b1, 10'd0, 32'h5700_0000);
    fill_words();
    read_words();
    drive(1'b1, 10'd0, 32'h5200_0000);
    read_words();

    cur_req = "R5";
    for (int i = 0; i < 3000; i++) drive(1'b0, 10'd515, 32'h0);

    cur_req = "R4";
    drive(1'b1, 10'd0, 32'h5300_0000);
    fill_words();
    read_words();
    drive(1'b1, 10'd0, 32'h0000_0000);
    fill_words();
    read_words();
    drive(1'b1, 10'd0, 32'h5200_0000);
    read_words();
    drive(1'b1, 10'd0, 32'h5700_0000);
    read_words();

    cur_req = "R9";
    drive(1'b1, 10'd0, 32'h57A5_C33C);
    drive(1'b0, 10'd0, 32'h0);
    drive(1'b1, 10'd3, 32'hFFFF_FFFF);
    drive(1'b0, 10'd3, 32'h0);
    drive(1'b0, 10'd0, 32'h0);

    cur_req = "R6";
    addr_mode = 1;
    for (int i = 0; i < 200; i++) drive(1'b0, 10'd512, 32'h0);
    addr_mode = 0;

    cur_req = "R7";
    drive(1'b1, 10'd1, 32'hFFFF_FFFE);
    drive(1'b0, 10'd1, 32'h0);
    drive(1'b1, 10'd1, 32'h0000_0001);
    drive(1'b0, 10'd1, 32'h0);
    drive(1'b1, 10'd1, 32'h0000_0000);
    drive(1'b0, 10'd1, 32'h0);

    cur_req = "R8";
    drive(1'b0, 10'd2, 32'h0);
    drive(1'b1, 10'd0, 32'h5200_0000);
    fill_words();
    drive(1'b0, 10'd2, 32'h0);
    read_words();
    drive(1'b1, 10'd0, 32'h5700_0000);
    fill_words();
    read_words();
    for (int i = 0; i < 500; i++) drive(1'b0, 10'd2, 32'h0);

    cur_req = "R9";
    drive(1'b1, 10'd0, 32'h1234_5678);
    drive(1'b0, 10'd0, 32'h0);
    drive(1'b0, 10'd1023, 32'h0);

    drive(1'b0, 10'd0, 32'h0);
    @(posedge clk);
    #15;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule